// File: doc/BRIEF.md
# Serial Pattern Detector Test Sequencer

This block tests a bit-serial pattern detector from the outside. It drives the detector's clock, data and reset lines itself. When the active-low start button is pressed, it loads a 32-bit LFSR from the seed input. It draws a stream of pseudo-random bits from the LFSR into a buffer. While filling the buffer it marks every bit position where the target pattern completes, counting matches non-overlapping.

It then pulses the detector's reset for one bit period. Next it shifts the stream out on the data line, generating a slow detector clock from the system clock. One system cycle after each rising edge of that clock, it samples the detector's result line and compares it with the precomputed mark for that bit.

When the last bit has gone out, it reports pass or fail, together with the expected and observed match counts. It then waits for the next press. A new press reloads the LFSR from the seed.

Top module: `seqtest_top`

## Requirements
- R1: After reset, busy, done, pass, both counts, det_clk, det_rst and det_data are all 0.
- R2: A run starts only on a high-to-low transition of start_n (low means pressed) while idle; presses during a run are ignored and produce no extra done pulse or extra bits.
- R3: Before the first data bit, det_rst is held high for exactly one bit period (PERIOD_TU*TU_CYCLES system cycles), and det_clk has no rising edge while det_rst is high.
- R4: Each run sends exactly STREAM_BITS (default 256) bits, one per rising edge of det_clk.
- R5: Each data bit is stable on det_data for at least SETUP_TU*TU_CYCLES system cycles before the det_clk rising edge that takes it. Consecutive rising edges are PERIOD_TU*TU_CYCLES cycles apart; the defaults give 4 and 10 cycles.
- R6: exp_count equals the number of non-overlapping occurrences of the pattern 1,1,0,1 in the transmitted stream, in transmission order. After a match the search restarts and the completed bits are not reused.
- R7: obs_count equals the number of bits for which det_result was high when it was sampled, one system cycle after that bit's rising edge.
- R8: pass is 1 only if det_result matched the expected mark at every bit. A mismatch clears pass at the end of the run, but the full stream is still sent.
- R9: done is a one-cycle pulse at the end of a run, and busy falls in that same cycle. pass and both counts hold their values until the next run starts.
- R10: The stream comes from a 32-bit LFSR loaded from seed at start, and a zero seed is replaced by 32'h1D872B41. Runs with different nonzero seeds therefore send different streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Start button, low when pressed |
| seed | input | 32 | LFSR seed taken at each start |
| det_result | input | 1 | Result line from the detector under test |
| det_clk | output | 1 | Generated detector clock |
| det_data | output | 1 | Serial data to the detector |
| det_rst | output | 1 | Reset pulse to the detector |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run |
| exp_count | output | 9 | Expected matches in the last run |
| obs_count | output | 9 | Observed result highs in the last run |

## Verification
The hardest case to reach is a faulty detector: a run must send every bit and still end with pass low. The bench can switch its own behavioural detector to a stuck-low result, so the fail path and the continuation of the stream are both exercised.

The zero-seed substitution cannot be seen from a single run. It is shown by comparing the streams captured from a zero seed and from the substitute constant. A start press is also issued halfway through a run, to show that it is ignored.

// File: rtl/seqtest_pkg.sv
package seqtest_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GEN  = 2'd1,
        PH_RST  = 2'd2,
        PH_SEND = 2'd3
    } phase_t;

    // Strobes from the bit-period timer
    typedef struct packed {
        logic pre_rise;   // cycle before the detector clock rises
        logic sample;     // first cycle with the detector clock high
        logic last;       // final cycle of the bit period
    } tick_t;

    localparam logic [31:0] LFSR_TAPS  = 32'hA300_0000;
    localparam logic [31:0] SEED_SUBST = 32'h1D87_2B41;

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction

endpackage

// File: rtl/seqtest_lfsr.sv
module seqtest_lfsr
    import seqtest_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] seed,
    input  logic        step,
    output logic        bit_out
);
    logic [31:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED_SUBST;
        end else if (load) begin
            state_q <= (seed == 32'd0) ? SEED_SUBST : seed;
        end else if (step) begin
            state_q <= lfsr_step(state_q);
        end
    end

    assign bit_out = state_q[0];

    a_r10_never_zero: assert property (@(posedge clk) disable iff (rst)
        state_q != 32'd0);
endmodule

// File: rtl/seqtest_scan.sv
module seqtest_scan #(
    parameter int PAT_LEN = 4,
    parameter logic [PAT_LEN-1:0] PATTERN = 4'b1101
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic valid,
    input  logic bit_in,
    output logic match
);
    localparam int FW = $clog2(PAT_LEN);
    localparam logic [FW-1:0] FULL = FW'(PAT_LEN - 1);

    logic [PAT_LEN-2:0] win_q;
    logic [FW-1:0]      fill_q;

    assign match = valid && (fill_q == FULL) && ({win_q, bit_in} == PATTERN);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (valid) begin
            win_q <= {win_q[PAT_LEN-3:0], bit_in};
            if (match)
                fill_q <= '0;
            else if (fill_q != FULL)
                fill_q <= fill_q + FW'(1);
        end
    end

    // R6: a match needs PAT_LEN fresh bits, so two matches are never adjacent
    a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        match |=> !match);
endmodule

// File: rtl/seqtest_bitclk.sv
module seqtest_bitclk
    import seqtest_pkg::*;
#(
    parameter int PER  = 10,
    parameter int RISE = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    output tick_t tick
);
    localparam int TW = $clog2(PER);

    logic [TW-1:0] t_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            t_q <= '0;
        else if (t_q == TW'(PER - 1))
            t_q <= '0;
        else
            t_q <= t_q + TW'(1);
    end

    always_comb begin
        tick.pre_rise = run && (t_q == TW'(RISE - 1));
        tick.sample   = run && (t_q == TW'(RISE));
        tick.last     = run && (t_q == TW'(PER - 1));
    end

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tick.pre_rise, tick.sample, tick.last}));
endmodule

// File: rtl/seqtest_top.sv
module seqtest_top
    import seqtest_pkg::*;
#(
    parameter int STREAM_BITS = 256,
    parameter int PAT_LEN     = 4,
    parameter logic [PAT_LEN-1:0] PATTERN = 4'b1101,
    parameter int TU_CYCLES   = 2,
    parameter int SETUP_TU    = 2,
    parameter int PERIOD_TU   = 5,
    localparam int CW         = $clog2(STREAM_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_n,
    input  logic [31:0]   seed,
    input  logic          det_result,
    output logic          det_clk,
    output logic          det_data,
    output logic          det_rst,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic [CW-1:0] exp_count,
    output logic [CW-1:0] obs_count
);
    // RISE must be at least 1 and leave room for sampling before the period ends
    localparam int PER  = PERIOD_TU * TU_CYCLES;
    localparam int RISE = SETUP_TU * TU_CYCLES;
    localparam int IW   = $clog2(STREAM_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(STREAM_BITS - 1);

    phase_t                 phase_q;
    logic [IW-1:0]          idx_q;
    logic [STREAM_BITS-1:0] stream_q;
    logic [STREAM_BITS-1:0] mark_q;
    logic                   cur_mark_q;
    logic                   fail_q;
    logic [2:0]             sync_q;
    logic                   press;
    logic                   gen_bit;
    logic                   gen_match;
    tick_t                  tick;

    // Button synchronizer and press detection (active low)
    always_ff @(posedge clk) begin
        if (rst) sync_q <= 3'b111;
        else     sync_q <= {sync_q[1:0], start_n};
    end
    assign press = sync_q[2] && !sync_q[1];

    seqtest_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .load    (phase_q == PH_IDLE && press),
        .seed    (seed),
        .step    (phase_q == PH_GEN),
        .bit_out (gen_bit)
    );

    seqtest_scan #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_scan (
        .clk    (clk),
        .rst    (rst),
        .clear  (phase_q == PH_IDLE && press),
        .valid  (phase_q == PH_GEN),
        .bit_in (gen_bit),
        .match  (gen_match)
    );

    seqtest_bitclk #(.PER(PER), .RISE(RISE)) u_bitclk (
        .clk  (clk),
        .rst  (rst),
        .run  (phase_q == PH_RST || phase_q == PH_SEND),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            idx_q      <= '0;
            stream_q   <= '0;
            mark_q     <= '0;
            cur_mark_q <= 1'b0;
            fail_q     <= 1'b0;
            det_clk    <= 1'b0;
            det_data   <= 1'b0;
            det_rst    <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b0;
            pass       <= 1'b0;
            exp_count  <= '0;
            obs_count  <= '0;
        end else begin
            done <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (press) begin
                        phase_q   <= PH_GEN;
                        busy      <= 1'b1;
                        pass      <= 1'b0;
                        fail_q    <= 1'b0;
                        exp_count <= '0;
                        obs_count <= '0;
                        idx_q     <= '0;
                    end
                end
                PH_GEN: begin
                    // first generated bit ends up at position 0
                    stream_q <= {gen_bit, stream_q[STREAM_BITS-1:1]};
                    mark_q   <= {gen_match, mark_q[STREAM_BITS-1:1]};
                    if (gen_match) exp_count <= exp_count + CW'(1);
                    idx_q <= idx_q + IW'(1);
                    if (idx_q == LAST_IDX) begin
                        phase_q <= PH_RST;
                        idx_q   <= '0;
                        det_rst <= 1'b1;
                    end
                end
                PH_RST: begin
                    if (tick.last) begin
                        det_rst    <= 1'b0;
                        phase_q    <= PH_SEND;
                        det_data   <= stream_q[0];
                        cur_mark_q <= mark_q[0];
                        stream_q   <= {1'b0, stream_q[STREAM_BITS-1:1]};
                        mark_q     <= {1'b0, mark_q[STREAM_BITS-1:1]};
                    end
                end
                PH_SEND: begin
                    if (tick.pre_rise) det_clk <= 1'b1;
                    if (tick.sample) begin
                        if (det_result != cur_mark_q) fail_q <= 1'b1;
                        if (det_result) obs_count <= obs_count + CW'(1);
                    end
                    if (tick.last) begin
                        det_clk <= 1'b0;
                        if (idx_q == LAST_IDX) begin
                            phase_q  <= PH_IDLE;
                            busy     <= 1'b0;
                            done     <= 1'b1;
                            pass     <= !fail_q;
                            det_data <= 1'b0;
                            idx_q    <= '0;
                        end else begin
                            idx_q      <= idx_q + IW'(1);
                            det_data   <= stream_q[0];
                            cur_mark_q <= mark_q[0];
                            stream_q   <= {1'b0, stream_q[STREAM_BITS-1:1]};
                            mark_q     <= {1'b0, mark_q[STREAM_BITS-1:1]};
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R3: the detector clock stays low while its reset is driven
    a_r3_no_clk_in_reset: assert property (@(posedge clk) disable iff (rst)
        det_rst |-> !det_clk);
    // R5: data does not move on the cycle the detector clock rises
    a_r5_data_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(det_clk) |-> $stable(det_data));
    // R9: done is a single-cycle pulse and ends the busy window
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R2: outside a run no detector line toggles
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!det_clk && !det_rst));
    // R8: pass only appears together with the end of a run
    a_r8_pass_at_done: assert property (@(posedge clk) disable iff (rst)
        $rose(pass) |-> done);
endmodule

// File: tb/sim_seqtest_top.sv
`timescale 1ns/1ps
module sim_seqtest_top;
    localparam int N = 256;
    localparam real TCK = 8.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_n = 1'b1;
    logic [31:0] seed = 32'd0;
    logic det_result;
    logic det_clk, det_data, det_rst, busy, done, pass;
    logic [8:0] exp_count, obs_count;

    int n_checks = 0;
    int n_fail = 0;

    always #(TCK/2) clk = ~clk;

    seqtest_top u0 (
        .clk(clk), .rst(rst), .start_n(start_n), .seed(seed),
        .det_result(det_result), .det_clk(det_clk), .det_data(det_data),
        .det_rst(det_rst), .busy(busy), .done(done), .pass(pass),
        .exp_count(exp_count), .obs_count(obs_count)
    );

    // Behavioural detector under test (non-overlapping 1101, registered result)
    logic [1:0] dst;
    logic dres;
    logic stuck = 1'b0;
    always @(posedge det_clk or posedge det_rst) begin
        if (det_rst) begin
            dst <= 2'd0; dres <= 1'b0;
        end else begin
            dres <= (dst == 2'd3) && det_data;
            case (dst)
                2'd0: dst <= det_data ? 2'd1 : 2'd0;
                2'd1: dst <= det_data ? 2'd2 : 2'd0;
                2'd2: dst <= det_data ? 2'd2 : 2'd3;
                default: dst <= 2'd0;
            endcase
        end
    end
    assign det_result = stuck ? 1'b0 : dres;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: collects transmitted bits, timing and line activity
    logic bitq[$];
    logic [N-1:0] cap;
    int edges = 0, rst_rises = 0, clk_in_rst = 0, bad_period = 0, dones = 0;
    realtime last_chg = 0, last_rise = 0, min_setup = 1e9, rst_t0 = 0, rst_w = 0;

    always @(det_data) last_chg = $realtime;
    always @(posedge det_rst) begin rst_rises++; rst_t0 = $realtime; end
    always @(negedge det_rst) rst_w = $realtime - rst_t0;
    always @(posedge det_clk) begin
        if (det_rst) clk_in_rst++;
        if ($realtime - last_chg < min_setup) min_setup = $realtime - last_chg;
        if (edges > 0 && ($realtime - last_rise) != 10 * TCK) bad_period++;
        last_rise = $realtime;
        if (edges < N) cap[edges] = det_data;
        bitq.push_back(det_data);
        edges++;
    end
    always @(negedge clk) if (done) dones++;

    task automatic clear_mon();
        bitq.delete();
        edges = 0; rst_rises = 0; clk_in_rst = 0; bad_period = 0; dones = 0;
        min_setup = 1e9; rst_w = 0;
    endtask

    task automatic press();
        @(negedge clk) start_n = 1'b0;
        repeat (4) @(negedge clk);
        start_n = 1'b1;
    endtask

    // Scoreboard: pop the collected bits and count non-overlapping 1101
    function automatic int model_matches();
        int fill = 0, m = 0;
        logic [3:0] w = 4'd0;
        while (bitq.size() > 0) begin
            w = {w[2:0], bitq.pop_front()};
            fill++;
            if (fill >= 4 && w == 4'b1101) begin m++; fill = 0; end
        end
        return m;
    endfunction

    task automatic run(input logic [31:0] s, input bit mid_press,
                       output logic [N-1:0] stream, output int m);
        clear_mon();
        seed = s;
        press();
        if (mid_press) begin
            repeat (1000) @(negedge clk);
            press();
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        stream = cap;
        m = model_matches();
    endtask

    logic [N-1:0] sa, sb, sc, sd;
    int ma, mb, mc, md;

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && pass == 0, "R1", "status after reset", {busy, done, pass}, 0);
        check(exp_count == 0 && obs_count == 0, "R1", "counts after reset", exp_count + obs_count, 0);
        check(det_clk == 0 && det_rst == 0 && det_data == 0, "R1", "detector lines", {det_clk, det_rst, det_data}, 0);
        repeat (50) @(negedge clk);
        check(busy == 0 && edges == 0, "R2", "no run without press", edges, 0);

        // Run A: good detector, extra press mid-run
        run(32'h1234_5678, 1'b1, sa, ma);
        check(edges == N, "R4", "bits sent", edges, N);
        check(dones == 1, "R2", "done pulses with mid-run press", dones, 1);
        check(rst_rises == 1 && rst_w == 10 * TCK, "R3", "reset pulse width ns", longint'(rst_w), longint'(10 * TCK));
        check(clk_in_rst == 0, "R3", "clock edges during reset", clk_in_rst, 0);
        check(min_setup >= 4 * TCK, "R5", "min setup ns", longint'(min_setup), longint'(4 * TCK));
        check(bad_period == 0, "R5", "bad bit periods", bad_period, 0);
        check(exp_count == ma, "R6", "expected matches", exp_count, ma);
        check(ma > 0, "R6", "stream has matches", ma, 1);
        check(obs_count == ma, "R7", "observed matches", obs_count, ma);
        check(pass == 1, "R8", "pass with good detector", pass, 1);
        check(busy == 0, "R9", "busy low after done", busy, 0);
        repeat (20) @(negedge clk);
        check(pass == 1 && exp_count == ma, "R9", "results held", exp_count, ma);

        // R10 zero seed substitution and seed dependence
        run(32'h0000_0000, 1'b0, sb, mb);
        check(exp_count == mb, "R6", "expected matches seed 0", exp_count, mb);
        run(32'h1D87_2B41, 1'b0, sc, mc);
        check(sb == sc, "R10", "zero seed equals substitute stream", sb == sc, 1);
        check(sa != sb, "R10", "different seeds differ", sa != sb, 1);

        // R8 faulty detector: stuck low result
        stuck = 1'b1;
        run(32'hCAFE_0101, 1'b0, sd, md);
        check(edges == N, "R8", "full stream despite mismatch", edges, N);
        check(pass == 0, "R8", "fail with stuck detector", pass, 0);
        check(obs_count == 0, "R7", "observed with stuck detector", obs_count, 0);
        check(exp_count == md, "R6", "expected matches seed 3", exp_count, md);
        stuck = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule